// File: doc/BRIEF.md
# CORDIC Vectoring Unit (angle and magnitude)

This block turns a fixed-point vector (x, y) into polar form. It computes the four-quadrant angle atan2(y, x) and the length of the vector. The datapath is fully unrolled: one register stage moves the vector into the right half-plane, one stage follows for each shift-add vectoring step, and an optional stage removes the CORDIC gain. A new vector can be accepted on every enabled clock edge. The magnitude has the same binary point as the inputs. The angle is given in radians with FQ fraction bits.

A parameter selects the input kind. In signed mode the inputs are two's complement and the angle covers the whole circle. In unsigned mode the inputs are plain binaries and the angle stays in the first quadrant. A second parameter selects the magnitude mode. In raw mode the magnitude still carries the gain K ≈ 1.64676. In compensated mode it is multiplied by a rounded 1/K. The enable input stalls the whole pipeline. The asynchronous reset clears every stage.

Top module: `cordic_vec`

## Requirements
- R1: With SIGNED_IN=1 the angle output is FQ+3 bits, two's complement, in units of 2^-FQ rad. It is within 3 LSB of round(atan2(y,x)·2^FQ) and never leaves [-π, +π].
- R2: With SIGNED_IN=0 the angle output is FQ+2 bits. It is within 3 LSB of round(atan2(y,x)·2^FQ), lies in [0, π/2] and never has its top bit set.
- R3: With COMPENSATE=0 the magnitude output is W_IN+2 bits, unsigned, in input LSB units. It is within 2 LSB of round(1.646760258·sqrt(x²+y²)).
- R4: With COMPENSATE=1 the magnitude output is W_IN+1 bits, unsigned. It is within 2 LSB of round(sqrt(x²+y²)).
- R5: In signed mode, inputs with x < 0 are resolved correctly. (-2^(W_IN-1), 0) yields about +π. A negative y with negative x yields an angle near -π.
- R6: The input (0, 0) yields an angle of exactly 0 and a magnitude of exactly 0.
- R7: A vector sampled on an enabled edge appears at the outputs after FQ+3+COMPENSATE enabled edges, counting the sampling edge. Before that, the outputs show the reset value 0 or earlier results.
- R8: An edge with en low changes no state and the outputs hold. After such a stall the stream resumes with no vector lost or repeated.
- R9: While arst is high, every stage is cleared at once, without waiting for a clock. Both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| arst | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Pipeline advance enable |
| x_i | input | W_IN | x coordinate (two's complement or unsigned per SIGNED_IN) |
| y_i | input | W_IN | y coordinate, same format as x_i |
| ang_o | output | FQ+3 or FQ+2 | atan2(y, x) in units of 2^-FQ rad, signed container |
| mag_o | output | W_IN+2 or W_IN+1 | Vector length, raw gain or compensated |

## Verification
Two events can meet on one edge: a finished result reaches the outputs, and en is low. When that happens the stall must freeze the output rather than let the result pass. Random en patterns, plus a long low stretch, drop en at many points while the pipeline is full. After every edge the outputs are compared with the vector that the count of enabled edges selects. A held output must equal the last expected result, and the vectors that follow a stall must come out in order with none missing. Both pipelines are run side by side with different latencies, so stalls hit them at different depths.

// File: rtl/cordic_vec.sv
`timescale 1ns/1ps
module cordic_vec #(
  parameter int W_IN = 12,
  parameter int FQ = 14,
  parameter bit SIGNED_IN = 1'b1,
  parameter bit COMPENSATE = 1'b0,
  localparam int AW = SIGNED_IN ? FQ + 3 : FQ + 2,
  localparam int MW = W_IN + (COMPENSATE ? 1 : 2)
) (
  input  logic                 clk,
  input  logic                 arst,
  input  logic                 en,
  input  logic [W_IN-1:0]      x_i,
  input  logic [W_IN-1:0]      y_i,
  output logic signed [AW-1:0] ang_o,
  output logic [MW-1:0]        mag_o
);
  localparam int N  = FQ + 2;
  localparam int G  = FQ + 2;
  localparam int GA = $clog2(N) + 1;
  localparam int FA = FQ + GA;
  localparam int AZ = FA + 3;
  localparam int IW = W_IN + 3 + G;
  localparam int KF = FQ + 2;
  localparam int PW = IW + KF;
  localparam int SH = COMPENSATE ? G + KF : G;
  localparam logic [63:0] PI60 = 64'h3243F6A8885A308D;

  // atan(2^-i) scaled by 2^62, from its odd power series
  function automatic logic [63:0] atan62(int i);
    logic [63:0] p, s;
    if (i == 0) return PI60;
    p = 64'd1 << (62 - i);
    s = '0;
    for (int k = 0; k < 40; k++) begin
      if (k % 2 == 0) s = s + p / 64'(2 * k + 1);
      else            s = s - p / 64'(2 * k + 1);
      p = p >> (2 * i);
    end
    return s;
  endfunction

  function automatic logic [N-1:0][AZ-1:0] mk_tab();
    logic [N-1:0][AZ-1:0] t;
    for (int i = 0; i < N; i++)
      t[i] = AZ'((atan62(i) + (64'd1 << (61 - FA))) >> (62 - FA));
    return t;
  endfunction

  localparam logic [N-1:0][AZ-1:0] ATAB = mk_tab();
  localparam logic signed [AZ-1:0] HALFPI = AZ'((PI60 + (64'd1 << (60 - FA))) >> (61 - FA));
  localparam logic signed [AZ-1:0] ZHALF = AZ'(64'd1 << (GA - 1));
  localparam logic [KF-1:0] INVK = KF'((64'h9B74EDA8 + (64'd1 << (31 - KF))) >> (32 - KF));
  localparam logic [PW-1:0] MHALF = PW'(1) << (SH - 1);

  logic sx, sy, zin;
  logic signed [IW-1:0] xe, ye, xp, yp;
  logic signed [AZ-1:0] zp;

  assign sx  = SIGNED_IN & x_i[W_IN-1];
  assign sy  = SIGNED_IN & y_i[W_IN-1];
  assign xe  = {{(IW-W_IN){sx}}, x_i} << G;
  assign ye  = {{(IW-W_IN){sy}}, y_i} << G;
  assign zin = (x_i == '0) && (y_i == '0);

  // fold the left half-plane onto the right by a quarter turn
  always_comb begin
    xp = xe;
    yp = ye;
    zp = '0;
    if (sx) begin
      if (!sy) begin
        xp = ye;
        yp = -xe;
        zp = HALFPI;
      end else begin
        xp = -ye;
        yp = xe;
        zp = -HALFPI;
      end
    end
  end

  logic signed [IW-1:0] xs [0:N];
  logic signed [IW-1:0] ys [0:N];
  logic signed [AZ-1:0] zs [0:N];
  logic [N:0]           zf;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      for (int i = 0; i <= N; i++) begin
        xs[i] <= '0;
        ys[i] <= '0;
        zs[i] <= '0;
      end
      zf <= '0;
    end else if (en) begin
      xs[0] <= xp;
      ys[0] <= yp;
      zs[0] <= zp;
      zf[0] <= zin;
      for (int i = 0; i < N; i++) begin
        if (ys[i][IW-1]) begin
          xs[i+1] <= xs[i] - (ys[i] >>> i);
          ys[i+1] <= ys[i] + (xs[i] >>> i);
          zs[i+1] <= zs[i] - $signed(ATAB[i]);
        end else begin
          xs[i+1] <= xs[i] + (ys[i] >>> i);
          ys[i+1] <= ys[i] - (xs[i] >>> i);
          zs[i+1] <= zs[i] + $signed(ATAB[i]);
        end
        zf[i+1] <= zf[i];
      end
    end
  end

  logic [PW-1:0]        msrc;
  logic signed [AZ-1:0] zend;
  logic                 zero_end;

  generate
    if (COMPENSATE) begin : g_comp
      logic [PW-1:0]        prod;
      logic signed [AZ-1:0] zc;
      logic                 zc0;
      always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
          prod <= '0;
          zc   <= '0;
          zc0  <= 1'b0;
        end else if (en) begin
          prod <= PW'($unsigned(xs[N])) * PW'(INVK);
          zc   <= zs[N];
          zc0  <= zf[N];
        end
      end
      assign msrc     = prod;
      assign zend     = zc;
      assign zero_end = zc0;
    end else begin : g_raw
      assign msrc     = PW'($unsigned(xs[N]));
      assign zend     = zs[N];
      assign zero_end = zf[N];
    end
  endgenerate

  logic [PW-1:0]        mr;
  logic signed [AZ-1:0] zr;

  assign mr    = (msrc + MHALF) >> SH;
  assign zr    = (zend + ZHALF) >>> GA;
  assign mag_o = MW'(mr);
  assign ang_o = (zero_end || (!SIGNED_IN && zr[AZ-1])) ? '0 : AW'(zr);
endmodule

// File: rtl/cordic_vec_chk.sv
`timescale 1ns/1ps
module cordic_vec_chk #(
  parameter int W_IN = 12,
  parameter int FQ = 14,
  parameter bit SIGNED_IN = 1'b1,
  parameter bit COMPENSATE = 1'b0,
  parameter int AW = 17,
  parameter int MW = 14
) (
  input logic                 clk,
  input logic                 arst,
  input logic                 en,
  input logic signed [AW-1:0] ang_o,
  input logic [MW-1:0]        mag_o
);
  localparam longint ALIM  = SIGNED_IN ? (longint'(13) << FQ) / 4 : (longint'(7) << FQ) / 4;
  localparam longint MAXIN = SIGNED_IN ? (longint'(1) << (W_IN - 1)) : (longint'(1) << W_IN) - 1;
  localparam longint MLIM  = MAXIN * (COMPENSATE ? 183 : 299) / 128 + 2;

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (arst)
    !en |=> ($stable(ang_o) && $stable(mag_o)));

  a_r1_angle_range: assert property (@(posedge clk) disable iff (arst)
    (longint'(ang_o) <= ALIM) && (longint'(ang_o) >= -ALIM));

  a_r2_no_negative: assert property (@(posedge clk) disable iff (arst)
    (SIGNED_IN == 1'b0) |-> !ang_o[AW-1]);

  a_r3_mag_bound: assert property (@(posedge clk) disable iff (arst)
    longint'(mag_o) <= MLIM);

  always @(posedge clk) begin
    if (arst) begin
      a_r9_reset_zero: assert (ang_o == '0 && mag_o == '0);
    end
  end
endmodule

bind cordic_vec cordic_vec_chk #(
  .W_IN(W_IN), .FQ(FQ), .SIGNED_IN(SIGNED_IN), .COMPENSATE(COMPENSATE), .AW(AW), .MW(MW)
) u_chk (
  .clk(clk), .arst(arst), .en(en), .ang_o(ang_o), .mag_o(mag_o)
);

// File: tb/tb_cordic_vec.sv
`timescale 1ns/1ps
module tb_cordic_vec;
  localparam int W = 12;
  localparam int FQ = 14;
  localparam int LAT_S = FQ + 3;
  localparam int LAT_U = FQ + 4;
  localparam int STEPS = 2500;
  localparam int NDIR = 12;
  localparam real KG = 1.646760258;

  logic clk = 1'b0, arst = 1'b1, en = 1'b0;
  logic [W-1:0] xs_i = '0, ys_i = '0, xu_i = '0, yu_i = '0;
  logic signed [FQ+2:0] ang_s;
  logic [W+1:0] mag_s;
  logic signed [FQ+1:0] ang_u;
  logic [W:0] mag_u;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int hsx [0:4095];
  int hsy [0:4095];
  int hux [0:4095];
  int huy [0:4095];
  int dsx [NDIR] = '{0, 2047, -2048, -2048, 0, 0, -2048, 2047, -1, 1, -2048, 5};
  int dsy [NDIR] = '{0, 0, 0, -1, -2048, 2047, -2048, 2047, 1, -1, 2047, 0};
  int dux [NDIR] = '{0, 4095, 0, 4095, 1, 4095, 0, 3, 100, 0, 4095, 7};
  int duy [NDIR] = '{0, 0, 4095, 4095, 4095, 1, 0, 4, 0, 1, 2000, 7};

  always #2 clk = ~clk;

  cordic_vec #(.W_IN(W), .FQ(FQ), .SIGNED_IN(1'b1), .COMPENSATE(1'b0)) dut (
    .clk(clk), .arst(arst), .en(en), .x_i(xs_i), .y_i(ys_i), .ang_o(ang_s), .mag_o(mag_s));

  cordic_vec #(.W_IN(W), .FQ(FQ), .SIGNED_IN(1'b0), .COMPENSATE(1'b1)) dut_u (
    .clk(clk), .arst(arst), .en(en), .x_i(xu_i), .y_i(yu_i), .ang_o(ang_u), .mag_o(mag_u));

  task automatic chk(string req, int act, int exp, int tol);
    total++;
    if (act - exp > tol || exp - act > tol) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ang(int x, int y);
    return int'($atan2(real'(y), real'(x)) * real'(1 << FQ));
  endfunction

  function automatic int exp_mag(int x, int y, bit comp);
    real m;
    m = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
    if (!comp) m = m * KG;
    return int'(m);
  endfunction

  task automatic check_s(int idx, bit held);
    int x, y;
    string pre;
    x = hsx[idx];
    y = hsy[idx];
    pre = held ? "R8 held " : "";
    if (x == 0 && y == 0) begin
      chk({pre, "R6 signed zero angle"}, int'(ang_s), 0, 0);
      chk({pre, "R6 signed zero magnitude"}, int'(mag_s), 0, 0);
    end else begin
      chk({pre, (x < 0) ? "R5 left half-plane angle" : "R1 signed angle"}, int'(ang_s), exp_ang(x, y), 3);
      chk({pre, "R3 raw magnitude"}, int'(mag_s), exp_mag(x, y, 1'b0), 2);
    end
  endtask

  task automatic check_u(int idx, bit held);
    int x, y;
    string pre;
    x = hux[idx];
    y = huy[idx];
    pre = held ? "R8 held " : "";
    if (x == 0 && y == 0) begin
      chk({pre, "R6 unsigned zero angle"}, int'(ang_u), 0, 0);
      chk({pre, "R6 unsigned zero magnitude"}, int'(mag_u), 0, 0);
    end else begin
      chk({pre, "R2 unsigned angle"}, int'(ang_u), exp_ang(x, y), 3);
      chk({pre, "R2 unsigned angle sign"}, int'(ang_u[FQ+1]), 0, 0);
      chk({pre, "R4 compensated magnitude"}, int'(mag_u), exp_mag(x, y, 1'b1), 2);
    end
  endtask

  initial begin
    int e;
    bit en_prev;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset angle signed", int'(ang_s), 0, 0);
    chk("R9 reset magnitude signed", int'(mag_s), 0, 0);
    chk("R9 reset angle unsigned", int'(ang_u), 0, 0);
    chk("R9 reset magnitude unsigned", int'(mag_u), 0, 0);

    arst = 1'b0;
    en = 1'b1;
    xs_i = W'(1000); ys_i = W'(500); xu_i = W'(1000); yu_i = W'(500);
    for (int k = 1; k <= LAT_U; k++) begin
      @(negedge clk);
      xs_i = '0; ys_i = '0; xu_i = '0; yu_i = '0;
      if (k < LAT_S) chk("R7 signed result not yet out", int'(mag_s != 0), 0, 0);
      if (k == LAT_S) chk("R7 signed result on time", int'(mag_s != 0), 1, 0);
      if (k < LAT_U) chk("R7 unsigned result not yet out", int'(mag_u != 0), 0, 0);
      if (k == LAT_U) chk("R7 unsigned result on time", int'(mag_u != 0), 1, 0);
    end

    xs_i = W'(1000); ys_i = W'(500); xu_i = W'(1000); yu_i = W'(500);
    repeat (LAT_U + 1) @(negedge clk);
    chk("R9 precondition signed output busy", int'(mag_s != 0), 1, 0);
    arst = 1'b1;
    #1;
    chk("R9 async clear angle signed", int'(ang_s), 0, 0);
    chk("R9 async clear magnitude signed", int'(mag_s), 0, 0);
    chk("R9 async clear angle unsigned", int'(ang_u), 0, 0);
    chk("R9 async clear magnitude unsigned", int'(mag_u), 0, 0);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    arst = 1'b0;

    e = 0;
    en_prev = 1'b0;
    for (int c = 0; c < STEPS; c++) begin
      if (e >= LAT_S) check_s(e - LAT_S + 1, !en_prev);
      if (e >= LAT_U) check_u(e - LAT_U + 1, !en_prev);
      if (c < NDIR) begin
        en = 1'b1;
        xs_i = W'(dsx[c]); ys_i = W'(dsy[c]);
        xu_i = W'(dux[c]); yu_i = W'(duy[c]);
      end else begin
        if (c >= 300 && c < 330) en = 1'b0;
        else en = ($urandom_range(3) != 0);
        xs_i = W'(int'($urandom_range(4095)) - 2048);
        ys_i = W'(int'($urandom_range(4095)) - 2048);
        xu_i = W'($urandom_range(4095));
        yu_i = W'($urandom_range(4095));
      end
      if (en) begin
        e++;
        hsx[e] = int'($signed(xs_i));
        hsy[e] = int'($signed(ys_i));
        hux[e] = int'(xu_i);
        huy[e] = int'(yu_i);
      end
      en_prev = en;
      @(negedge clk);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule